// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block turns edges on a bank of interrupt pins into interrupt delivery messages. Each pin has a 64-bit routing entry, presented to the block as a flat input vector. The entry sets where the message goes, which vector it carries, the delivery mode, the addressing mode, the signal level and the trigger kind. The entries are programmed elsewhere. Only their current contents are used.

A pin fires when it goes from low to high. The event is held as pending until the engine serves it, lowest pin number first. A masked entry drops the event. A reserved delivery mode drops the event and raises an error pulse. A physically addressed entry sends one message. A logically addressed entry reads its 8-bit destination as a bitmask and sends one message to each set bit's index, in ascending order. Messages leave through a valid/ready port and stay stable while the port is stalled.

Top module: `irqRouteEngine`

## Requirements
- R1: A pin event is recorded only when the pin goes from low to high. Keeping the pin high or lowering it produces no message.
- R2: An entry whose mask bit (bit 16) is 1 drops its event. It sends no message and raises no error.
- R3: When the delivery mode is 3'b111, the message vector is `extVector`. In every other mode, the vector is the entry's bits 7:0.
- R4: Every message copies the entry's delivery mode (bits 10:8), addressing mode (bit 11), level (bit 13) and trigger kind (bit 15).
- R5: With addressing mode 0, an entry sends exactly one message, and its destination is the entry's bits 63:56.
- R6: With addressing mode 1, an entry sends one message for each set bit of bits 63:56. The destination is that bit's index, and the messages go out in ascending bit order.
- R7: An unmasked entry with delivery mode 3'b011 or 3'b110 sends no message. It raises `errReserved` for exactly one cycle.
- R8: Events that arrive in the same cycle, or while a fan-out is still in progress, are served in ascending pin order once the current message sequence has finished.
- R9: While `msgValid` is 1 and `msgReady` is 0, all message outputs hold their values. A fan-out moves to its next bit only after a completed handshake.
- R10: An unmasked logical entry with an all-zero destination mask sends no message and raises no error.
- R11: After reset, `msgValid` and `errReserved` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NUM_PINS | Interrupt pin levels |
| entryTable | input | NUM_PINS*64 | Routing entries; entry n occupies bits n*64 and up |
| extVector | input | 8 | Vector used in the external-interrupt mode |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Receiver accepts the message |
| msgDest | output | 8 | Destination ID of the message |
| msgVector | output | 8 | Interrupt vector |
| msgMode | output | 3 | Delivery mode |
| msgLogical | output | 1 | Addressing mode copied from the entry |
| msgLevel | output | 1 | Level copied from the entry |
| msgTrigger | output | 1 | Trigger kind copied from the entry |
| errReserved | output | 1 | One-cycle pulse when a reserved mode is dropped |

## Verification
Two functions can fall in the same cycle: a new pin edge, and the fan-out of an earlier event that is stalled or still stepping through its bits. The bench provokes this in two ways. It raises several pins together. It also raises a second pin part way through an eight-beat logical fan-out, while `msgReady` is throttled. The result is judged by the complete order of accepted messages: the first entry's beats must finish in ascending bit order before the later pin's message appears. On every stalled cycle, the bench also checks that the outputs are frozen.

// File: rtl/irqRoutePkg.sv
package irqRoutePkg;
  localparam int ENTRY_W  = 64;
  localparam int VEC_LO   = 0;
  localparam int MODE_LO  = 8;
  localparam int LOGIC_B  = 11;
  localparam int LEVEL_B  = 13;
  localparam int TRIG_B   = 15;
  localparam int MASK_B   = 16;
  localparam int DEST_LO  = 56;

  localparam logic [2:0] MODE_EXT = 3'b111;
  localparam logic [2:0] MODE_RSV_A = 3'b011;
  localparam logic [2:0] MODE_RSV_B = 3'b110;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
  } routeStrb_t;

  typedef enum logic {ST_IDLE, ST_SEND} routeState_t;
endpackage

// File: rtl/irqRouteCtrl.sv
module irqRouteCtrl
  import irqRoutePkg::*;
#(
  parameter int NUM_PINS = 4,
  localparam int IDXW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                selMasked,
  input  logic                selReserved,
  input  logic                selEmpty,
  input  logic                lastBeat,
  input  logic                msgReady,
  output routeStrb_t          strb,
  output logic [IDXW-1:0]     selIdx,
  output logic                msgValid,
  output logic                errReserved
);
  logic [NUM_PINS-1:0] pinState;
  logic [NUM_PINS-1:0] pending;
  logic [NUM_PINS-1:0] rise;
  logic [NUM_PINS-1:0] clrMask;
  logic                anyPend;
  logic                dropRsv;
  routeState_t         state, stateNext;

  assign rise    = pinIn & ~pinState;
  assign anyPend = |pending;

  // lowest numbered pending pin wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (pending[i]) selIdx = IDXW'(i);
    end
  end

  always_comb begin
    strb      = '0;
    clrMask   = '0;
    dropRsv   = 1'b0;
    stateNext = state;
    if (state == ST_IDLE) begin
      if (anyPend) begin
        clrMask[selIdx] = 1'b1;
        if (selMasked) begin
          stateNext = ST_IDLE;
        end else if (selReserved) begin
          dropRsv = 1'b1;
        end else if (!selEmpty) begin
          strb.load = 1'b1;
          stateNext = ST_SEND;
        end
      end
    end else if (msgReady) begin
      if (lastBeat) stateNext = ST_IDLE;
      else          strb.advance = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinState    <= '0;
      pending     <= '0;
      state       <= ST_IDLE;
      errReserved <= 1'b0;
    end else begin
      pinState    <= pinIn;
      pending     <= (pending & ~clrMask) | rise;
      state       <= stateNext;
      errReserved <= dropRsv;
    end
  end

  assign msgValid = (state == ST_SEND);

  // R7: an error pulse never coincides with an offered message
  p_err_no_msg_r7: assert property (@(posedge clk) disable iff (!rstN)
    errReserved |-> !msgValid);

  // R9: a loaded message is offered in the next cycle
  p_load_offers_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> msgValid);
endmodule

// File: rtl/irqRouteDatapath.sv
module irqRouteDatapath
  import irqRoutePkg::*;
#(
  parameter int NUM_PINS = 4,
  localparam int IDXW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PINS*ENTRY_W-1:0] entryTable,
  input  logic [7:0]                  extVector,
  input  logic [IDXW-1:0]             selIdx,
  input  routeStrb_t                  strb,
  output logic                        selMasked,
  output logic                        selReserved,
  output logic                        selEmpty,
  output logic                        lastBeat,
  output logic [7:0]                  msgDest,
  output logic [7:0]                  msgVector,
  output logic [2:0]                  msgMode,
  output logic                        msgLogical,
  output logic                        msgLevel,
  output logic                        msgTrigger
);
  logic [ENTRY_W-1:0] entries [NUM_PINS];
  logic [ENTRY_W-1:0] selEntry;
  logic [2:0]         selMode;
  logic [7:0]         selDest;
  logic               selLogical;
  logic [7:0]         remMask;
  logic [7:0]         nextMask;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_entry
    assign entries[g] = entryTable[g*ENTRY_W +: ENTRY_W];
  end

  function automatic logic [2:0] lowestBit(input logic [7:0] m);
    logic [2:0] r;
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      if (m[i]) r = 3'(i);
    end
    return r;
  endfunction

  assign selEntry    = entries[selIdx];
  assign selMode     = selEntry[MODE_LO +: 3];
  assign selDest     = selEntry[DEST_LO +: 8];
  assign selLogical  = selEntry[LOGIC_B];
  assign selMasked   = selEntry[MASK_B];
  assign selReserved = (selMode == MODE_RSV_A) || (selMode == MODE_RSV_B);
  assign selEmpty    = selLogical && (selDest == 8'h00);

  assign nextMask = remMask & (remMask - 8'd1);
  assign lastBeat = !msgLogical || (nextMask == 8'h00);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remMask    <= '0;
      msgDest    <= '0;
      msgVector  <= '0;
      msgMode    <= '0;
      msgLogical <= 1'b0;
      msgLevel   <= 1'b0;
      msgTrigger <= 1'b0;
    end else if (strb.load) begin
      remMask    <= selLogical ? selDest : 8'h00;
      msgDest    <= selLogical ? {5'd0, lowestBit(selDest)} : selDest;
      msgVector  <= (selMode == MODE_EXT) ? extVector : selEntry[VEC_LO +: 8];
      msgMode    <= selMode;
      msgLogical <= selLogical;
      msgLevel   <= selEntry[LEVEL_B];
      msgTrigger <= selEntry[TRIG_B];
    end else if (strb.advance) begin
      remMask <= nextMask;
      msgDest <= {5'd0, lowestBit(nextMask)};
    end
  end

  // R6: a stepping fan-out always has bits left to send
  p_step_has_bits_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |-> (msgLogical && $countones(remMask) > 1));
endmodule

// File: rtl/irqRouteEngine.sv
module irqRouteEngine
  import irqRoutePkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PINS-1:0]         pinIn,
  input  logic [NUM_PINS*ENTRY_W-1:0] entryTable,
  input  logic [7:0]                  extVector,
  output logic                        msgValid,
  input  logic                        msgReady,
  output logic [7:0]                  msgDest,
  output logic [7:0]                  msgVector,
  output logic [2:0]                  msgMode,
  output logic                        msgLogical,
  output logic                        msgLevel,
  output logic                        msgTrigger,
  output logic                        errReserved
);
  localparam int IDXW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  routeStrb_t      strb;
  logic [IDXW-1:0] selIdx;
  logic            selMasked, selReserved, selEmpty, lastBeat;

  irqRouteCtrl #(.NUM_PINS(NUM_PINS)) i_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .selMasked(selMasked), .selReserved(selReserved), .selEmpty(selEmpty),
    .lastBeat(lastBeat), .msgReady(msgReady), .strb(strb), .selIdx(selIdx),
    .msgValid(msgValid), .errReserved(errReserved)
  );

  irqRouteDatapath #(.NUM_PINS(NUM_PINS)) i_dp (
    .clk(clk), .rstN(rstN), .entryTable(entryTable), .extVector(extVector),
    .selIdx(selIdx), .strb(strb), .selMasked(selMasked),
    .selReserved(selReserved), .selEmpty(selEmpty), .lastBeat(lastBeat),
    .msgDest(msgDest), .msgVector(msgVector), .msgMode(msgMode),
    .msgLogical(msgLogical), .msgLevel(msgLevel), .msgTrigger(msgTrigger)
  );

  // R9: stalled message is frozen
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgDest) &&
      $stable(msgVector) && $stable(msgMode) && $stable(msgLogical) &&
      $stable(msgLevel) && $stable(msgTrigger)));

  // R6: logical fan-out destinations climb
  p_ascend_r6: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady && msgLogical && !lastBeat) |=>
      (msgValid && msgDest > $past(msgDest)));

  // R5: a physical message ends its sequence after one handshake
  p_single_phys_r5: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady && !msgLogical) |=> !msgValid);

  // R7: reserved modes never leave the block
  p_no_reserved_out_r7: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgMode != MODE_RSV_A && msgMode != MODE_RSV_B));
endmodule

// File: tb/test_irqRouteEngine.sv
module test_irqRouteEngine;
  localparam int NP = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NP-1:0]   pinIn = '0;
  logic [NP*64-1:0] entryTable = '0;
  logic [7:0]      extVector = 8'h00;
  logic            msgValid, msgReady, msgLogical, msgLevel, msgTrigger, errReserved;
  logic [7:0]      msgDest, msgVector;
  logic [2:0]      msgMode;

  always #5 clk = ~clk;

  irqRouteEngine #(.NUM_PINS(NP)) i_irqRouteEngine (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .entryTable(entryTable),
    .extVector(extVector), .msgValid(msgValid), .msgReady(msgReady),
    .msgDest(msgDest), .msgVector(msgVector), .msgMode(msgMode),
    .msgLogical(msgLogical), .msgLevel(msgLevel), .msgTrigger(msgTrigger),
    .errReserved(errReserved)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int readyMode = 0;
  logic [21:0] gotQ [64];
  logic [21:0] expQ [64];
  int gotN = 0, expN = 0, errGot = 0, expErr = 0;
  logic        prevValid = 1'b0, prevReady = 1'b0;
  logic [21:0] prevMsg = '0;

  function automatic logic [21:0] pack(logic [7:0] d, logic [7:0] v, logic [2:0] m,
                                       logic lg, logic lv, logic tr);
    return {d, v, m, lg, lv, tr};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: choose ready, record handshakes, check R9 stall hold
  always @(negedge clk) begin
    logic [21:0] cur;
    cyc++;
    case (readyMode)
      0: msgReady = 1'b1;
      1: msgReady = (cyc % 3) != 0;
      default: msgReady = (cyc % 4) == 0;
    endcase
    cur = pack(msgDest, msgVector, msgMode, msgLogical, msgLevel, msgTrigger);
    if (rstN) begin
      if (prevValid && !prevReady)
        check(msgValid && cur == prevMsg, "R9 stall hold", {10'd0, cur}, {10'd0, prevMsg});
      if (msgValid && msgReady && gotN < 64) begin
        gotQ[gotN] = cur;
        gotN++;
      end
      if (errReserved) errGot++;
    end
    prevValid = msgValid;
    prevReady = msgReady;
    prevMsg   = cur;
  end

  task automatic setEntry(int p, logic [7:0] vec, logic [2:0] mode, logic lg,
                          logic lv, logic tr, logic msk, logic [7:0] dst);
    logic [63:0] e;
    e = '0;
    e[7:0] = vec; e[10:8] = mode; e[11] = lg; e[13] = lv; e[15] = tr;
    e[16] = msk; e[63:56] = dst;
    entryTable[p*64 +: 64] = e;
  endtask

  task automatic addExpect(int p);
    logic [63:0] e;
    logic [7:0]  v;
    e = entryTable[p*64 +: 64];
    if (e[16]) return;
    if (e[10:8] == 3'b011 || e[10:8] == 3'b110) begin
      expErr++;
      return;
    end
    v = (e[10:8] == 3'b111) ? extVector : e[7:0];
    if (!e[11]) begin
      expQ[expN] = pack(e[63:56], v, e[10:8], 1'b0, e[13], e[15]);
      expN++;
    end else begin
      for (int b = 0; b < 8; b++) begin
        if (e[56+b]) begin
          expQ[expN] = pack(8'(b), v, e[10:8], 1'b1, e[13], e[15]);
          expN++;
        end
      end
    end
  endtask

  // raise 'first' pins together; optionally re-raise 'second' after a delay
  task automatic runCase(logic [NP-1:0] first, logic [NP-1:0] second, int dly, string req);
    gotN = 0; expN = 0; errGot = 0; expErr = 0;
    for (int p = 0; p < NP; p++) if (first[p]) addExpect(p);
    for (int p = 0; p < NP; p++) if (second[p]) addExpect(p);
    @(negedge clk); pinIn = pinIn | first;
    if (second != '0) begin
      repeat (dly) @(negedge clk);
      pinIn = pinIn & ~second;
      @(negedge clk); pinIn = pinIn | second;
    end
    repeat (60) @(negedge clk);
    pinIn = '0;
    repeat (6) @(negedge clk);
    check(gotN == expN, {req, " count"}, 32'(gotN), 32'(expN));
    for (int k = 0; k < expN && k < gotN; k++)
      check(gotQ[k] == expQ[k], {req, " message"}, {10'd0, gotQ[k]}, {10'd0, expQ[k]});
    check(errGot == expErr, {req, " error pulses"}, 32'(errGot), 32'(expErr));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(msgValid == 1'b0 && errReserved == 1'b0, "R11 reset outputs",
          {30'd0, msgValid, errReserved}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R7: every mode, both addressing kinds, mask on/off
    for (int m = 0; m < 8; m++) begin
      for (int lg = 0; lg < 2; lg++) begin
        for (int mk = 0; mk < 2; mk++) begin
          readyMode = (m + lg) % 2;
          extVector = 8'(8'hC0 + m);
          setEntry(1, 8'(8'h20 + m * 3), 3'(m), lg[0], m[0], m[1], mk[0],
                   lg ? 8'hA5 : 8'h3C);
          runCase(4'b0010, 4'b0000, 0, "R2/R3/R4/R5/R7 mode sweep");
        end
      end
    end

    // R6 R10: every logical destination mask
    for (int d = 0; d < 256; d++) begin
      readyMode = d % 3;
      setEntry(0, 8'(d), 3'b000, 1'b1, d[1], d[2], 1'b0, 8'(d));
      runCase(4'b0001, 4'b0000, 0, "R6/R10 logical mask sweep");
    end

    // R8: simultaneous events served lowest pin first
    readyMode = 1;
    setEntry(1, 8'h41, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11);
    setEntry(2, 8'h42, 3'b001, 1'b0, 1'b1, 1'b0, 1'b0, 8'h22);
    setEntry(3, 8'h43, 3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 8'h33);
    runCase(4'b1110, 4'b0000, 0, "R8 simultaneous order");

    // R8 R9: event arrives during a throttled eight-beat fan-out
    readyMode = 2;
    setEntry(0, 8'h50, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
    runCase(4'b0001, 4'b0100, 4, "R8 event during fan-out");

    // R1: hold high, drop and re-raise -> exactly two messages
    readyMode = 0;
    setEntry(0, 8'h61, 3'b010, 1'b0, 1'b1, 1'b1, 1'b0, 8'h07);
    runCase(4'b0001, 4'b0001, 20, "R1 edge only");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule